// File: doc/BRIEF.md
# Masked Pattern Match Trace Monitor

This block sits beside a 64-bit trace data source and decides, sample by sample, whether the data is worth capturing. It also decides whether a captured sample should raise a trigger, a timestamp request, or both. Software sets it up through a small 32-bit register port before turning it on. That setup covers two pattern/mask pairs, one for the trigger and one for the timestamp, each 64 bits wide and split over two registers. It also covers a collection-mode bit and a separate timestamp enable.

In continuous mode every valid sample counts as captured. In change-only mode a sample is captured only when it differs from the last captured one. The first valid sample after the block is turned on is always captured. Each captured sample is compared against both masked patterns. All three outputs are registered single-cycle strobes that appear one clock after the sample: the capture strobe, the trigger pulse and the timestamp request.

Top module: `pattern_trace_monitor`

## Requirements
- R1: Registers are 32 bits wide and both readable and writable at these offsets: 0xA08/0xA0C timestamp pattern, 0xA10/0xA14 timestamp mask, 0xA18/0xA1C trigger pattern and 0xA20/0xA24 trigger mask. A read of any other offset returns zero, and a write to any other offset changes nothing.
- R2: The control register is at 0xA00. Bit 0 turns the monitor on. Bit 1 picks the mode: 0 is continuous and 1 is change-only. Its other bits read as zero.
- R3: A mask bit of 1 makes the matching data bit take part in the comparison, and a mask bit of 0 makes it don't-care. An all-zero mask matches every sample.
- R4: The trigger pulse is high for one cycle, in the cycle after a captured sample that matches the trigger pattern under the trigger mask.
- R5: The timestamp request is high in the cycle after a captured sample that matches the timestamp pattern under its mask. It fires only while bit 0 of register 0xA04 is set; the other bits of 0xA04 read as zero.
- R6: In continuous mode every valid sample is captured, and the capture strobe follows one cycle later, repeated values included.
- R7: In change-only mode a sample is captured only when it differs from the last captured sample. The first valid sample after the monitor is turned on is always captured.
- R8: While the monitor is off, no capture strobe, trigger pulse or timestamp request is produced.
- R9: The register at the lower offset of each pair (base + 0) holds data bits 31:0, and the one at base + 4 holds bits 63:32. All 64 bits take part in the comparison.
- R10: After reset, all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| smp_valid | input | 1 | A new sample is present on smp_data |
| smp_data | input | 64 | Monitored sample |
| trig_pulse | output | 1 | Trigger match strobe |
| ts_req | output | 1 | Timestamp request strobe |
| cap_strobe | output | 1 | Sample captured strobe |

## Verification
On every cycle the assertions check several properties:
- no output appears while the monitor is off or when no sample was offered;
- trigger and timestamp strobes only accompany a capture;
- each strobe's sample really matched its pattern under the mask in force at that time;
- the timestamp enable was set for every timestamp request;
- two back-to-back captures in change-only mode carried different data;
- unmapped reads return zero.

Only the bench scenarios can show the remaining behaviour. That covers strobes that are missing when they should fire: a repeated value in continuous mode, the forced first capture after re-enable, a zero mask matching everything, and the upper-word mismatch. It also covers register readback.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int unsigned TM_REG_W  = 32;
  localparam int unsigned TM_ADDR_W = 12;
  localparam int unsigned TM_DATA_W = 64;

  // byte offsets of the register map
  localparam logic [TM_ADDR_W-1:0] OFS_CTRL   = 12'hA00;
  localparam logic [TM_ADDR_W-1:0] OFS_TSCTL  = 12'hA04;
  localparam logic [TM_ADDR_W-1:0] OFS_TS_PAT = 12'hA08;
  localparam logic [TM_ADDR_W-1:0] OFS_TS_MSK = 12'hA10;
  localparam logic [TM_ADDR_W-1:0] OFS_TG_PAT = 12'hA18;
  localparam logic [TM_ADDR_W-1:0] OFS_TG_MSK = 12'hA20;

  typedef struct packed {
    logic on_change;  // bit 1
    logic en;         // bit 0
  } tm_ctrl_t;
endpackage

// File: rtl/tmon_regs.sv
module tmon_regs
  import tmon_pkg::*;
#(
  parameter int unsigned REG_W  = TM_REG_W,
  parameter int unsigned ADDR_W = TM_ADDR_W,
  parameter int unsigned NWORD  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  output tm_ctrl_t                ctrl,
  output logic                    ts_en,
  output logic [NWORD*REG_W-1:0]  ts_pat,
  output logic [NWORD*REG_W-1:0]  ts_msk,
  output logic [NWORD*REG_W-1:0]  tg_pat,
  output logic [NWORD*REG_W-1:0]  tg_msk
);
  localparam int unsigned STRIDE = REG_W / 8;

  tm_ctrl_t ctrl_q, ctrl_d;
  logic     tsen_q, tsen_d;
  logic [NWORD-1:0][REG_W-1:0] tsp_q, tsp_d, tsm_q, tsm_d;
  logic [NWORD-1:0][REG_W-1:0] tgp_q, tgp_d, tgm_q, tgm_d;

  function automatic logic hit_word(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input int unsigned idx);
    return a == (base + ADDR_W'(idx * STRIDE));
  endfunction

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    tsen_d = tsen_q;
    tsp_d  = tsp_q;
    tsm_d  = tsm_q;
    tgp_d  = tgp_q;
    tgm_d  = tgm_q;
    if (wr_en) begin
      if (addr == OFS_CTRL) begin
        ctrl_d.en        = wdata[0];
        ctrl_d.on_change = wdata[1];
      end
      if (addr == OFS_TSCTL) tsen_d = wdata[0];
      for (int i = 0; i < NWORD; i++) begin
        if (hit_word(addr, OFS_TS_PAT, i)) tsp_d[i] = wdata;
        if (hit_word(addr, OFS_TS_MSK, i)) tsm_d[i] = wdata;
        if (hit_word(addr, OFS_TG_PAT, i)) tgp_d[i] = wdata;
        if (hit_word(addr, OFS_TG_MSK, i)) tgm_d[i] = wdata;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tsen_q <= 1'b0;
      tsp_q  <= '0;
      tsm_q  <= '0;
      tgp_q  <= '0;
      tgm_q  <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
      tsen_q <= tsen_d;
      tsp_q  <= tsp_d;
      tsm_q  <= tsm_d;
      tgp_q  <= tgp_d;
      tgm_q  <= tgm_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == OFS_CTRL)  rdata = {{(REG_W-2){1'b0}}, ctrl_q.on_change, ctrl_q.en};
    if (addr == OFS_TSCTL) rdata = {{(REG_W-1){1'b0}}, tsen_q};
    for (int i = 0; i < NWORD; i++) begin
      if (hit_word(addr, OFS_TS_PAT, i)) rdata = tsp_q[i];
      if (hit_word(addr, OFS_TS_MSK, i)) rdata = tsm_q[i];
      if (hit_word(addr, OFS_TG_PAT, i)) rdata = tgp_q[i];
      if (hit_word(addr, OFS_TG_MSK, i)) rdata = tgm_q[i];
    end
  end

  assign ctrl   = ctrl_q;
  assign ts_en  = tsen_q;
  assign ts_pat = tsp_q;
  assign ts_msk = tsm_q;
  assign tg_pat = tgp_q;
  assign tg_msk = tgm_q;
endmodule

// File: rtl/tmon_match.sv
module tmon_match #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SLICE  = 32
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] pat,
  input  logic [DATA_W-1:0] msk,
  output logic              hit
);
  localparam int unsigned NSLICE = DATA_W / SLICE;

  logic [NSLICE-1:0] slice_ok;

  // one reduction per slice, then a final AND
  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign slice_ok[s] =
      ~|((data[s*SLICE +: SLICE] ^ pat[s*SLICE +: SLICE]) & msk[s*SLICE +: SLICE]);
  end

  assign hit = &slice_ok;
endmodule

// File: rtl/tmon_capture.sv
module tmon_capture #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              on_change,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              take
);
  logic [DATA_W-1:0] last_q, last_d;
  logic              first_q, first_d;
  logic              differs;

  assign differs = smp_data != last_q;
  assign take    = en & smp_valid & (~on_change | first_q | differs);

  always_comb begin
    last_d  = last_q;
    first_d = first_q;
    if (!en) begin
      first_d = 1'b1;
    end else if (take) begin
      first_d = 1'b0;
      last_d  = smp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      first_q <= 1'b1;
    end else begin
      first_q <= first_d;
      if (take) last_q <= last_d;
    end
  end
endmodule

// File: rtl/pattern_trace_monitor.sv
module pattern_trace_monitor
  import tmon_pkg::*;
#(
  parameter int unsigned REG_W  = TM_REG_W,
  parameter int unsigned ADDR_W = TM_ADDR_W,
  parameter int unsigned DATA_W = TM_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              trig_pulse,
  output logic              ts_req,
  output logic              cap_strobe
);
  localparam int unsigned NWORD = DATA_W / REG_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  tm_ctrl_t          ctl;
  logic              mon_en, mon_chg, ts_en;
  logic [DATA_W-1:0] ts_pat, ts_msk, tg_pat, tg_msk;
  logic              take, ts_hit, tg_hit;

  tmon_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .NWORD(NWORD)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .ctrl   (ctl),
    .ts_en  (ts_en),
    .ts_pat (ts_pat),
    .ts_msk (ts_msk),
    .tg_pat (tg_pat),
    .tg_msk (tg_msk)
  );

  assign mon_en  = ctl.en;
  assign mon_chg = ctl.on_change;

  tmon_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .en        (mon_en),
    .on_change (mon_chg),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .take      (take)
  );

  tmon_match #(.DATA_W(DATA_W), .SLICE(REG_W)) u_ts_cmp (
    .data (smp_data), .pat (ts_pat), .msk (ts_msk), .hit (ts_hit)
  );

  tmon_match #(.DATA_W(DATA_W), .SLICE(REG_W)) u_tg_cmp (
    .data (smp_data), .pat (tg_pat), .msk (tg_msk), .hit (tg_hit)
  );

  // output strobes
  logic cap_d, trig_d, ts_d;
  logic cap_q, trig_q, ts_q;

  always_comb begin
    cap_d  = take;
    trig_d = take & tg_hit;
    ts_d   = take & ts_hit & ts_en;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cap_q  <= 1'b0;
      trig_q <= 1'b0;
      ts_q   <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      trig_q <= trig_d;
      ts_q   <= ts_d;
    end
  end

  assign cap_strobe = cap_q;
  assign trig_pulse = trig_q;
  assign ts_req     = ts_q;
endmodule

// File: rtl/tmon_checker.sv
module tmon_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [11:0]       reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_data,
  input logic              trig_pulse,
  input logic              ts_req,
  input logic              cap_strobe,
  input logic              mon_en,
  input logic              mon_chg,
  input logic              ts_en,
  input logic [DATA_W-1:0] ts_pat,
  input logic [DATA_W-1:0] ts_msk,
  input logic [DATA_W-1:0] tg_pat,
  input logic [DATA_W-1:0] tg_msk
);
  logic mapped;
  assign mapped = (reg_addr >= 12'hA00) && (reg_addr <= 12'hA24) && (reg_addr[1:0] == 2'b00);

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> reg_rdata == '0);

  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !cap_strobe && !trig_pulse && !ts_req);

  p_cap_needs_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !cap_strobe);

  p_trig_with_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> cap_strobe);

  p_trig_masked_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> ((($past(smp_data) ^ $past(tg_pat)) & $past(tg_msk)) == '0));

  p_ts_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ts_req |-> cap_strobe && $past(ts_en) &&
               ((($past(smp_data) ^ $past(ts_pat)) & $past(ts_msk)) == '0));

  p_change_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe && $past(cap_strobe) && $past(mon_chg) |-> $past(smp_data) != $past(smp_data, 2));
endmodule

bind pattern_trace_monitor tmon_checker #(.DATA_W(DATA_W)) u_tmon_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .trig_pulse (trig_pulse),
  .ts_req     (ts_req),
  .cap_strobe (cap_strobe),
  .mon_en     (mon_en),
  .mon_chg    (mon_chg),
  .ts_en      (ts_en),
  .ts_pat     (ts_pat),
  .ts_msk     (ts_msk),
  .tg_pat     (tg_pat),
  .tg_msk     (tg_msk)
);

// File: tb/pattern_trace_monitor_tb_top.sv
module pattern_trace_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        smp_valid;
  logic [63:0] smp_data;
  logic        trig_pulse, ts_req, cap_strobe;

  always #10 clk = ~clk;  // 50 MHz

  pattern_trace_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .trig_pulse(trig_pulse), .ts_req(ts_req),
    .cap_strobe(cap_strobe)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference model state
  bit          m_en = 0, m_chg = 0, m_tsen = 0, m_first = 1;
  logic [63:0] m_tsp = '0, m_tsm = '0, m_tgp = '0, m_tgm = '0, m_last = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, predict, compare after the edge
  task automatic step(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                      input bit v, input logic [63:0] d, input string note,
                      output logic [31:0] rd);
    bit take, e_tg, e_ts;
    string ctag;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd; smp_valid = v; smp_data = d;
    #1 rd = reg_rdata;
    take = m_en && v && (!m_chg || m_first || d != m_last);
    e_tg = take && (((d ^ m_tgp) & m_tgm) == 64'd0);
    e_ts = take && m_tsen && (((d ^ m_tsp) & m_tsm) == 64'd0);
    ctag = !m_en ? "R8" : (m_chg ? "R7" : "R6");
    if (take) begin m_last = d; m_first = 0; end
    if (!m_en) m_first = 1;
    if (wr) begin
      case (a)
        12'hA00: begin m_en = wd[0]; m_chg = wd[1]; end
        12'hA04: m_tsen = wd[0];
        12'hA08: m_tsp[31:0]  = wd;
        12'hA0C: m_tsp[63:32] = wd;
        12'hA10: m_tsm[31:0]  = wd;
        12'hA14: m_tsm[63:32] = wd;
        12'hA18: m_tgp[31:0]  = wd;
        12'hA1C: m_tgp[63:32] = wd;
        12'hA20: m_tgm[31:0]  = wd;
        12'hA24: m_tgm[63:32] = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    #5;
    chk({note, " capture ", ctag}, cap_strobe, take);
    chk({note, " trigger R4"}, trig_pulse, e_tg);
    chk({note, " timestamp R5"}, ts_req, e_ts);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string note);
    logic [31:0] rd;
    step(1'b1, a, d, 1'b0, 64'd0, note, rd);
  endtask

  task automatic smp(input logic [63:0] d, input string note);
    logic [31:0] rd;
    step(1'b0, 12'h000, 32'd0, 1'b1, d, note, rd);
  endtask

  task automatic idle(input string note);
    logic [31:0] rd;
    step(1'b0, 12'h000, 32'd0, 1'b0, 64'd0, note, rd);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string note);
    logic [31:0] rd;
    step(1'b0, a, 32'd0, 1'b0, 64'd0, note, rd);
    chk({note, " readback"}, rd, exp);
  endtask

  localparam logic [63:0] TG = 64'hDEAD_BEEF_0000_1234;

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0; smp_valid = 0; smp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk("R10 reset cap", cap_strobe, 0);
    chk("R10 reset trig", trig_pulse, 0);
    chk("R10 reset ts", ts_req, 0);
    for (int i = 0; i < 10; i++) rd_chk(12'hA00 + 12'(4 * i), 32'd0, "R10 reset reg");

    // R1 / R9 register map and word order
    wr(12'hA08, 32'h1111_1111, "R1"); wr(12'hA0C, 32'h2222_2222, "R1");
    wr(12'hA10, 32'h3333_3333, "R1"); wr(12'hA14, 32'h4444_4444, "R1");
    wr(12'hA18, 32'h5555_5555, "R1"); wr(12'hA1C, 32'h6666_6666, "R1");
    wr(12'hA20, 32'h7777_7777, "R1"); wr(12'hA24, 32'h8888_8888, "R1");
    wr(12'hA04, 32'hFFFF_FFFF, "R5");
    wr(12'hA28, 32'hFFFF_FFFF, "R1 unmapped write");
    rd_chk(12'hA08, 32'h1111_1111, "R1"); rd_chk(12'hA0C, 32'h2222_2222, "R1");
    rd_chk(12'hA10, 32'h3333_3333, "R1"); rd_chk(12'hA14, 32'h4444_4444, "R1");
    rd_chk(12'hA18, 32'h5555_5555, "R1"); rd_chk(12'hA1C, 32'h6666_6666, "R1");
    rd_chk(12'hA20, 32'h7777_7777, "R1"); rd_chk(12'hA24, 32'h8888_8888, "R1");
    rd_chk(12'hA04, 32'h0000_0001, "R5 ts enable bit");
    rd_chk(12'hA28, 32'd0, "R1 unmapped");
    rd_chk(12'hA02, 32'd0, "R1 unaligned");
    rd_chk(12'h000, 32'd0, "R1 unmapped low");
    wr(12'hA00, 32'hFFFF_FFFC, "R2");
    rd_chk(12'hA00, 32'd0, "R2 upper bits");

    // configure patterns
    wr(12'hA18, TG[31:0], "cfg"); wr(12'hA1C, TG[63:32], "cfg");
    wr(12'hA20, 32'hFFFF_FFFF, "cfg"); wr(12'hA24, 32'hFFFF_FFFF, "cfg");
    wr(12'hA08, 32'd0, "cfg"); wr(12'hA0C, 32'h0000_00AB, "cfg");
    wr(12'hA10, 32'd0, "cfg"); wr(12'hA14, 32'h0000_00FF, "cfg");
    wr(12'hA04, 32'd0, "R5 off");

    // R8 disabled: nothing comes out
    smp(TG, "R8 off"); smp(64'h0000_00AB_1234_5678, "R8 off");

    // R6 continuous
    wr(12'hA00, 32'h1, "R2 enable");
    rd_chk(12'hA00, 32'h1, "R2");
    smp(TG, "R6 match"); smp(64'h1, "R6 miss"); smp(TG, "R6 repeat"); smp(TG, "R6 repeat");
    idle("R6 idle");
    smp(64'h0000_00AB_9999_0000, "R5 ts disabled");
    wr(12'hA04, 32'h1, "R5 on");
    smp(64'h0000_00AB_9999_0000, "R5 ts enabled");
    smp(64'h0000_00AC_9999_0000, "R5 ts miss");
    // R9 each word matters
    smp(TG ^ 64'h1, "R9 low word");
    smp(TG ^ (64'h1 << 40), "R9 high word");
    // R3 masks
    wr(12'hA20, 32'd0, "R3"); wr(12'hA24, 32'd0, "R3");
    smp(64'h0123_4567_89AB_CDEF, "R3 zero mask"); smp(64'd0, "R3 zero mask");
    wr(12'hA20, 32'h1, "R3");
    smp(64'hFFFF_FFFF_FFFF_FFF0, "R3 bit0 only");
    smp(64'hFFFF_FFFF_FFFF_FFF1, "R3 bit0 only");
    wr(12'hA24, 32'h8000_0000, "R9"); wr(12'hA1C, 32'h8000_0000, "R9");
    smp(64'h8000_0000_0000_0000, "R9 bit63");
    smp(64'h0000_0000_0000_0000, "R9 bit63");

    // R7 change-only
    wr(12'hA00, 32'h3, "R7 mode");
    rd_chk(12'hA00, 32'h3, "R2");
    smp(64'h0000_0000_0000_0000, "R7 same as last");
    smp(64'h55, "R7 differs");
    smp(64'h55, "R7 same");
    idle("R7 idle");
    smp(64'h55, "R7 same after gap");
    smp(64'h56, "R7 differs");
    wr(12'hA00, 32'h2, "R8 off");
    smp(64'h77, "R8 off");
    wr(12'hA00, 32'h3, "R7 reenable");
    smp(64'h56, "R7 first after enable");
    smp(64'h56, "R7 same");
    wr(12'hA00, 32'h0, "R8 off");
    smp(64'h99, "R8 off"); smp(64'h0, "R8 off");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule